// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block produces the SCL waveform and the SDA timing strobes of an I2C master, one bus phase at a time. A byte sequencer asks for a phase (START, one data bit, STOP or repeated START) with a one-cycle request. The block then drives SCL low or releases it, pulses a change strobe at each point where SDA must move, pulses a sample strobe where read data is valid, and ends with a one-cycle done pulse. The sequencer owns the SDA level and the bit order. This block only says when to act.

Every duration is programmed in prescaled ticks. Two timing sets, one for fast speed and one for high speed, each come as three packed 32-bit words. A fourth word holds the data-hold count, which both sets share. The sequencer picks the set with each request, so a high-speed transfer can run its first phases on the fast set and then switch. Input glitch filtering is modelled as a pure delay of the SCL input. Together with a fixed edge-settling allowance, this delay sets the fixed part of each SCL high time.

Top module: `i2c_phase_timer`

## Requirements

Timing is counted in cycles. Cycle 1 is the first clock period after the edge that accepts a request. D is divisor+1 and E is the parameter EDGE_CLKS (default 8).

- R1: After reset, SCL is released (`scl_low`=0) and `sda_chg`, `sda_smp` and `done` are all 0.
- R2: The timing words have this layout:
  - Word 1: start setup [31:24], start hold [23:16], stop setup [15:8].
  - Word 2: data setup [31:24], SCL low [15:8], SCL high [7:0].
  - Word 3: divisor [23:16], repeated-start release [7:0].
  - Hold word: data hold [7:0].
  
  A tick occurs every D clocks, and all segment lengths are counted in ticks. `scl_low` is high for exactly Lseg*D cycles of a BIT, STOP or RSTART phase and for none of a START phase.
- R3: BIT (phase code 1), when low ≥ hold+setup+1: `scl_low` covers cycles 1..(low+1)*D, and `done` pulses in cycle D*(low+high+2)+E+F.
- R4: The filter delay F is 2*`filt_cyc` when FILT_SINGLE=0 and `filt_cyc` when FILT_SINGLE=1.
- R5: The low segment lasts Lseg = max(base, hold+setup+1)+1 ticks, where base is the SCL low field (the release field for RSTART). Its `sda_chg` pulse falls in cycle (hold+1)*D.
- R6: START (code 0): SCL stays released. `sda_chg` pulses in cycle (su+1)*D and `done` in cycle (su+hd+2)*D.
- R7: STOP (code 2): after the low segment and rise, SCL stays high for ps+1 ticks. The second `sda_chg` and `done` both fall in cycle Lseg*D+E+F+(ps+1)*D.
- R8: RSTART (code 3): low segment and rise first. Then the second `sda_chg` pulses in cycle Lseg*D+E+F+(su+1)*D, and `done` pulses (hd+1)*D cycles later.
- R9: `sda_smp` pulses once, only in BIT phases, in the last cycle of the rise wait (cycle Lseg*D+E+F when nothing stretches).
- R10: When an external device holds SCL low for S cycles after the release, the rise ends in cycle Lseg*D + max(E+F, S+1+F), and everything after it shifts by the same amount.
- R11: `hs_sel`=1 selects the high-speed words and 0 the fast words. The choice is latched when a request is accepted, and later changes of `hs_sel` in that phase have no effect.
- R12: A request while a phase runs is ignored. Each phase gives exactly one `done` pulse, with 1 change strobe for START and BIT and 2 for STOP and RSTART.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Phase request, taken only when idle |
| phase | input | 2 | 0 START, 1 BIT, 2 STOP, 3 RSTART |
| hs_sel | input | 1 | Timing set select: 1 high speed, 0 fast |
| fs_t1 | input | 32 | Fast set word 1 |
| fs_t2 | input | 32 | Fast set word 2 |
| fs_t3 | input | 32 | Fast set word 3 |
| hs_t1 | input | 32 | High-speed set word 1 |
| hs_t2 | input | 32 | High-speed set word 2 |
| hs_t3 | input | 32 | High-speed set word 3 |
| hold_t | input | 32 | Shared data-hold word |
| filt_cyc | input | 3 | Filter cycle count |
| scl_in | input | 1 | Observed SCL line level |
| scl_low | output | 1 | Drive SCL low |
| sda_chg | output | 1 | SDA may change now |
| sda_smp | output | 1 | Sample SDA now |
| done | output | 1 | Phase complete |

## Verification

The sweeps cover the following corners:

- **Divisor.** The sweeps cover divisors 0 and 2. A prescaler that restarted late, or ran freely across segments, would move every edge by a fraction of a tick.
- **Low-time extension.** Some settings have hold+setup above the low count. A design that ignored the extension would put the change strobe outside the low segment or shorten SCL low.
- **Filter delay.** Two builds check the doubled and single filter delays side by side. An off-by-one in the delay tap would skew every rise by one cycle.
- **Clock stretching.** Long stretches prove that the rise waits for the delayed line rather than a free counter. A stretch shorter than the settling allowance must leave the timing unchanged.
- **Busy-time inputs.** Spurious requests and `hs_sel` toggles inside a phase must not add a done pulse or change the durations.

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int EDGE_CLKS   = 8,
  parameter bit FILT_SINGLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  phase,
  input  logic        hs_sel,
  input  logic [31:0] fs_t1,
  input  logic [31:0] fs_t2,
  input  logic [31:0] fs_t3,
  input  logic [31:0] hs_t1,
  input  logic [31:0] hs_t2,
  input  logic [31:0] hs_t3,
  input  logic [31:0] hold_t,
  input  logic [2:0]  filt_cyc,
  input  logic        scl_in,
  output logic        scl_low,
  output logic        sda_chg,
  output logic        sda_smp,
  output logic        done
);
  localparam int FMAX = FILT_SINGLE ? 7 : 14;
  localparam int RCW  = $clog2(EDGE_CLKS + FMAX + 1);
  localparam int SW   = 10;
  localparam logic [1:0] PH_START = 2'd0, PH_BIT = 2'd1, PH_STOP = 2'd2, PH_RSTART = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SU, S_HD, S_LOW, S_RISE, S_HIGH, S_PSU} st_t;
  st_t st;
  logic [1:0]      ph;
  logic            hs_q;
  logic [7:0]      pc;
  logic [SW-1:0]   sc;
  logic [RCW-1:0]  rc;
  logic [FMAX-1:0] sh;

  wire [31:0] w1 = hs_q ? hs_t1 : fs_t1;
  wire [31:0] w2 = hs_q ? hs_t2 : fs_t2;
  wire [31:0] w3 = hs_q ? hs_t3 : fs_t3;
  wire [7:0]  dv = w3[23:16];
  wire [SW-1:0] dh   = {2'b0, hold_t[7:0]};
  wire [SW-1:0] base = {2'b0, (ph == PH_RSTART) ? w3[7:0] : w2[15:8]};
  wire [SW-1:0] need = dh + {2'b0, w2[31:24]} + SW'(1);
  wire [SW-1:0] low_last = (base > need) ? base : need;

  wire [3:0] fdel = FILT_SINGLE ? {1'b0, filt_cyc} : {filt_cyc, 1'b0};
  wire [FMAX:0] tap = {sh, scl_in};
  wire scl_f = tap[fdel];
  wire [RCW-1:0] rise_lim = RCW'(EDGE_CLKS - 1) + RCW'(fdel);

  logic [SW-1:0] seg_last;
  always_comb begin
    case (st)
      S_SU:    seg_last = {2'b0, w1[31:24]};
      S_HD:    seg_last = {2'b0, w1[23:16]};
      S_PSU:   seg_last = {2'b0, w1[15:8]};
      S_HIGH:  seg_last = {2'b0, w2[7:0]};
      default: seg_last = low_last;
    endcase
  end

  wire ticking = (st != S_IDLE) && (st != S_RISE);
  wire tick    = ticking && (pc == dv);
  wire last    = tick && (sc == seg_last);
  wire rise_ok = (st == S_RISE) && (rc == rise_lim) && scl_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= PH_START;
      hs_q <= 1'b0;
      pc   <= '0;
      sc   <= '0;
      rc   <= '0;
      sh   <= '1;
    end else begin
      sh <= {sh[FMAX-2:0], scl_in};
      if (st == S_IDLE) begin
        if (req) begin
          ph   <= phase;
          hs_q <= hs_sel;
          pc   <= '0;
          sc   <= '0;
          rc   <= '0;
          st   <= (phase == PH_START) ? S_SU : S_LOW;
        end
      end else if (st == S_RISE) begin
        rc <= rc + RCW'(rc != rise_lim);
        if (rise_ok)
          st <= (ph == PH_BIT) ? S_HIGH : (ph == PH_STOP) ? S_PSU : S_SU;
      end else begin
        pc <= tick ? '0 : pc + 8'd1;
        if (tick) sc <= last ? '0 : sc + SW'(1);
        if (last) begin
          case (st)
            S_SU:    st <= S_HD;
            S_LOW:   begin st <= S_RISE; rc <= '0; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign scl_low = (st == S_LOW);
  assign sda_chg = ((st == S_LOW) && tick && (sc == dh)) ||
                   (((st == S_SU) || (st == S_PSU)) && last);
  assign sda_smp = rise_ok && (ph == PH_BIT);
  assign done    = last && ((st == S_HD) || (st == S_HIGH) || (st == S_PSU));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_scl_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scl_low);
  p_smp_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_smp |-> !scl_low);
  p_stretch_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_RISE) && !scl_f) |=> (st == S_RISE));
  p_set_latched_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(hs_q));
  p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ticking |-> (pc <= dv));
  p_chg_not_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_chg |-> (st != S_RISE));
endmodule

// File: tb/i2c_phase_timer_tb.sv
module i2c_phase_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EDGE = 8;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, hs_sel = 1'b0, stretch = 1'b0;
  logic [1:0] phase = 2'd0;
  logic [2:0] filt = 3'd0;
  logic [31:0] fs_t1 = '0, fs_t2 = '0, fs_t3 = '0, hs_t1 = '0, hs_t2 = '0, hs_t3 = '0, hold_t = '0;
  logic scl_low, sda_chg, sda_smp, done;
  logic scl_low_b, chg_b, smp_b, done_b;
  logic scl_a, scl_b;
  assign scl_a = ~(scl_low | stretch);
  assign scl_b = ~(scl_low_b | stretch);

  int n_cmp = 0, n_bad = 0;
  int su[2], hd[2], ps[2], ds[2], lo[2], hi[2], dv[2], rl[2];
  int dh;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_phase_timer #(.EDGE_CLKS(EDGE), .FILT_SINGLE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .phase(phase), .hs_sel(hs_sel),
    .fs_t1(fs_t1), .fs_t2(fs_t2), .fs_t3(fs_t3), .hs_t1(hs_t1), .hs_t2(hs_t2), .hs_t3(hs_t3),
    .hold_t(hold_t), .filt_cyc(filt), .scl_in(scl_a),
    .scl_low(scl_low), .sda_chg(sda_chg), .sda_smp(sda_smp), .done(done));

  i2c_phase_timer #(.EDGE_CLKS(EDGE), .FILT_SINGLE(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .req(req), .phase(phase), .hs_sel(hs_sel),
    .fs_t1(fs_t1), .fs_t2(fs_t2), .fs_t3(fs_t3), .hs_t1(hs_t1), .hs_t2(hs_t2), .hs_t3(hs_t3),
    .hold_t(hold_t), .filt_cyc(filt), .scl_in(scl_b),
    .scl_low(scl_low_b), .sda_chg(chg_b), .sda_smp(smp_b), .done(done_b));

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic load_words();
    fs_t1 = {8'(su[0]), 8'(hd[0]), 8'(ps[0]), 8'h00};
    fs_t2 = {8'(ds[0]), 8'h00, 8'(lo[0]), 8'(hi[0])};
    fs_t3 = {8'h00, 8'(dv[0]), 8'h00, 8'(rl[0])};
    hs_t1 = {8'(su[1]), 8'(hd[1]), 8'(ps[1]), 8'h00};
    hs_t2 = {8'(ds[1]), 8'h00, 8'(lo[1]), 8'(hi[1])};
    hs_t3 = {8'h00, 8'(dv[1]), 8'h00, 8'(rl[1])};
    hold_t = {24'h0, 8'(dh)};
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_done(input int ph, input int s, input int f, input int strs);
    int d, ls, r;
    d  = dv[s] + 1;
    ls = mx((ph == 3) ? rl[s] : lo[s], dh + ds[s] + 1) + 1;
    r  = ls * d + mx(EDGE + f, strs + 1 + f);
    case (ph)
      0: return (su[s] + hd[s] + 2) * d;
      1: return r + (hi[s] + 1) * d;
      2: return r + (ps[s] + 1) * d;
      default: return r + (su[s] + hd[s] + 2) * d;
    endcase
  endfunction

  task automatic run_phase(input int ph, input int s, input int strs, input bit toggle);
    int d, ls, f, fb, rise, e_done, e_done_b, e_c1, e_c2, e_smp, e_low, e_nchg, lim;
    int g_done, g_done_b, g_c1, g_c2, g_smp, g_low, n_done, n_done_b, n_chg, n;
    string tag;
    d  = dv[s] + 1;
    f  = 2 * int'(filt);
    fb = int'(filt);
    ls = mx((ph == 3) ? rl[s] : lo[s], dh + ds[s] + 1) + 1;
    rise = ls * d + mx(EDGE + f, strs + 1 + f);
    e_done   = exp_done(ph, s, f, strs);
    e_done_b = exp_done(ph, s, fb, strs);
    e_low  = (ph == 0) ? 0 : ls * d;
    e_c1   = (ph == 0) ? (su[s] + 1) * d : (dh + 1) * d;
    e_c2   = (ph == 2) ? rise + (ps[s] + 1) * d : (ph == 3) ? rise + (su[s] + 1) * d : 0;
    e_smp  = (ph == 1) ? rise : 0;
    e_nchg = (ph >= 2) ? 2 : 1;
    tag = (ph == 0) ? "R6" : (ph == 1) ? "R3" : (ph == 2) ? "R7" : "R8";
    if (strs > 0) tag = "R10";
    if (toggle) tag = "R11";
    g_done = 0; g_done_b = 0; g_c1 = 0; g_c2 = 0; g_smp = 0; g_low = 0;
    n_done = 0; n_done_b = 0; n_chg = 0; n = 0;
    lim = mx(e_done, e_done_b) + 6;
    @(negedge clk);
    phase = 2'(ph); hs_sel = s[0]; req = 1'b1;
    while (n < lim && n < 3000) begin
      @(negedge clk);
      n++;
      req = (n == 1);
      if (n == 1) phase = 2'(3 - ph);
      if (toggle && n == 2) hs_sel = ~s[0];
      stretch = (ph != 0) && (n >= ls * d + 1) && (n <= ls * d + strs);
      #1;
      if (done && g_done == 0) g_done = n;
      if (done_b && g_done_b == 0) g_done_b = n;
      n_done += int'(done);
      n_done_b += int'(done_b);
      if (sda_chg) begin
        n_chg++;
        if (g_c1 == 0) g_c1 = n; else if (g_c2 == 0) g_c2 = n;
      end
      if (sda_smp && g_smp == 0) g_smp = n;
      g_low += int'(scl_low);
    end
    stretch = 1'b0;
    req = 1'b0;
    if (n >= 3000) check("R12", "phase watchdog", n, lim);
    check(tag, "done cycle", g_done, e_done);
    check("R4", "single-filter done cycle", g_done_b, e_done_b);
    check("R5", "first change strobe", g_c1, e_c1);
    check(tag, "second change strobe", g_c2, e_c2);
    check((ph == 1 && strs > 0) ? "R10" : "R9", "sample strobe", g_smp, e_smp);
    check("R2", "scl low cycles", g_low, e_low);
    check("R12", "done pulses", n_done, 1);
    check("R12", "done pulses single", n_done_b, 1);
    check("R12", "change strobes", n_chg, e_nchg);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    su = '{2, 1}; hd = '{1, 0}; ps = '{3, 1}; ds = '{3, 0};
    lo = '{1, 3}; hi = '{2, 0}; dv = '{0, 1}; rl = '{2, 1};
    dh = 0;
    load_words();
    repeat (3) @(negedge clk);
    check("R1", "scl_low at reset", int'(scl_low), 0);
    check("R1", "sda_chg at reset", int'(sda_chg), 0);
    check("R1", "sda_smp at reset", int'(sda_smp), 0);
    check("R1", "done at reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "scl_low after reset", int'(scl_low), 0);

    for (int dvi = 0; dvi < 2; dvi++)
      for (int fi = 0; fi < 2; fi++)
        for (int li = 0; li < 2; li++)
          for (int hi_i = 0; hi_i < 2; hi_i++)
            for (int ph = 0; ph < 4; ph++)
              for (int s = 0; s < 2; s++) begin
                dv[0] = 2 * dvi;
                filt  = 3'(3 * fi);
                lo[0] = li ? 6 : 1;
                dh    = 2 * hi_i;
                load_words();
                run_phase(ph, s, 0, 1'b0);
              end

    dv[0] = 1; filt = 3'd2; lo[0] = 4; dh = 1;
    load_words();
    run_phase(1, 0, 12, 1'b0);
    run_phase(1, 0, 3, 1'b0);
    run_phase(2, 1, 15, 1'b0);
    run_phase(3, 0, 20, 1'b0);
    run_phase(1, 0, 0, 1'b1);
    run_phase(1, 1, 0, 1'b1);
    run_phase(0, 1, 0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule